// File: doc/BRIEF.md
# Memory and I/O Cycle Router

This block sits between a 32-bit processor bus and the things that bus can reach. For each accepted bus cycle it works out whether the target is main memory or one of a few device ports. It then raises the matching select and direction strobes and hands a one-cycle ready pulse, read data and an error flag back to the processor. Memory cycles take a fixed number of clocks. A device cycle lasts until the addressed port acknowledges it.

A mode input chooses between two decoding schemes. In the separate I/O space scheme, the I/O-versus-memory strobe decides the target, and only the low 16 address bits form the port number. In the windowed scheme, the strobe is not used. Instead, a 64 KB address window, set by a parameter and aligned to 64 KB, is steered to the ports, and every other address goes to memory. The port numbers are fixed by a parameter. When a device access matches no port, it is closed by a timeout so that the processor never stalls.

The processor holds its address, strobes and write data steady, with the valid signal high, until it sees ready. It then drops valid.

Top module: `bus_cycle_router`

## Requirements
- R1: A memory cycle raises `mem_sel` for exactly one cycle, starting the cycle after acceptance. `mem_we` equals the inverse of `rd_wr` (rd_wr=1 read, 0 write). `cpu_ready` pulses in the following cycle, carrying `mem_rdata` for a read and zero for a write.
- R2: With `mode_mmio`=0, `io_m`=1 makes a device cycle and `io_m`=0 makes a memory cycle whatever the address. Port matching uses only `addr[15:0]`, and bits 31..16 have no effect.
- R3: With `mode_mmio`=1, an address whose bits 31..16 equal those of `WIN_BASE` is a device cycle, and any other address is a memory cycle. `io_m` has no effect.
- R4: In a device cycle, bit i of `port_sel` (i = 0..3) is the only bit set, and only when the port number exactly equals entry i of `PORT_NUMS`. The defaults are 0x0060, 0x0064, 0x03F8 and 0x01F0 for i = 0..3.
- R5: A read to a port raises `dev_rd`, and a write to the same port number raises `dev_wr` and drives the held write data on `wr_data`. The two are never high together.
- R6: A device cycle to a matched port ends only when that port's `port_ready` bit is high. `cpu_ready` follows one cycle later with that port's read data, or zero for a write. Ready bits of unselected ports are ignored.
- R7: A device cycle that matches no port ends with `cpu_ready` in the 16th cycle after the select phase begins, with `cpu_rdata` all ones and `cpu_err` high.
- R8: `cpu_ready` is a single-cycle pulse. `cyc_valid` is not accepted while a cycle is in flight or during the ready cycle.
- R9: While reset is held and after it is released with no valid cycle, every output is zero.
- R10: `cpu_err` is high only together with `cpu_ready` at the end of an unmatched device cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mmio | input | 1 | 0 selects separate I/O space decoding, 1 selects windowed decoding |
| cyc_valid | input | 1 | Processor cycle request, held until ready |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle (separate I/O space mode only) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 32 | Cycle address |
| wdata | input | 32 | Write data, meaningful on writes only |
| mem_rdata | input | 32 | Read data from memory |
| port_ready | input | 4 | Per-port data-ready or acknowledge |
| port_rdata | input | 128 | Per-port read data, port i in bits 32i+31..32i |
| mem_sel | output | 1 | Memory select |
| mem_we | output | 1 | Memory write enable |
| port_sel | output | 4 | One-hot port select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| wr_data | output | 32 | Latched write data to memory and ports |
| cpu_ready | output | 1 | Cycle-complete pulse to the processor |
| cpu_rdata | output | 32 | Read data to the processor |
| cpu_err | output | 1 | Unmatched device access flag |

## Verification
Two events can land in the same cycle: an acknowledge from a port that is not selected, and the cycle in which the router is waiting on another port or counting toward its timeout. The bench drives ready on unselected ports during a matched access and during an unmatched one. It then judges the ready latency, the returned data and the error flag, all of which must be the same as without the stray acknowledges. The bench also keeps valid high through the ready cycle, and confirms that no new select appears in the cycle that follows.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DEV  = 2'd2,
        ST_DONE = 2'd3
    } brc_state_e;
endpackage

// File: rtl/brc_decode.sv
module brc_decode #(
    parameter int ADDR_W = 32,
    parameter int IO_AW = 16,
    parameter int N_PORTS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hB000_0000,
    parameter logic [N_PORTS*IO_AW-1:0] PORT_NUMS = {16'h01F0, 16'h03F8, 16'h0064, 16'h0060}
) (
    input  logic              mode_mmio,
    input  logic              io_m,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_io,
    output logic [N_PORTS-1:0] hit
);
    logic in_window;
    logic [IO_AW-1:0] port_num;

    assign in_window = (addr[ADDR_W-1:IO_AW] == WIN_BASE[ADDR_W-1:IO_AW]);
    assign is_io     = mode_mmio ? in_window : io_m;
    assign port_num  = addr[IO_AW-1:0];

    for (genvar i = 0; i < N_PORTS; i++) begin : g_cmp
        assign hit[i] = is_io && (port_num == PORT_NUMS[i*IO_AW +: IO_AW]);
    end
endmodule

// File: rtl/brc_port_mux.sv
module brc_port_mux #(
    parameter int N_PORTS = 4,
    parameter int DATA_W = 32
) (
    input  logic [N_PORTS-1:0]        sel,
    input  logic [N_PORTS-1:0]        port_ready,
    input  logic [N_PORTS*DATA_W-1:0] port_rdata,
    output logic                      any_ready,
    output logic [DATA_W-1:0]         rdata
);
    logic [DATA_W-1:0] masked [N_PORTS];

    for (genvar i = 0; i < N_PORTS; i++) begin : g_mask
        assign masked[i] = sel[i] ? port_rdata[i*DATA_W +: DATA_W] : '0;
    end

    assign any_ready = |(sel & port_ready);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            rdata = rdata | masked[i];
        end
    end
endmodule

// File: rtl/bus_cycle_router.sv
module bus_cycle_router
    import brc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IO_AW = 16,
    parameter int N_PORTS = 4,
    parameter int TIMEOUT = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hB000_0000,
    parameter logic [N_PORTS*IO_AW-1:0] PORT_NUMS = {16'h01F0, 16'h03F8, 16'h0064, 16'h0060}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_mmio,
    input  logic                      cyc_valid,
    input  logic                      io_m,
    input  logic                      rd_wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    input  logic [N_PORTS-1:0]        port_ready,
    input  logic [N_PORTS*DATA_W-1:0] port_rdata,
    output logic                      mem_sel,
    output logic                      mem_we,
    output logic [N_PORTS-1:0]        port_sel,
    output logic                      dev_rd,
    output logic                      dev_wr,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      cpu_ready,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      cpu_err
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        brc_state_e         state;
        logic               rd;
        logic               mem_sel;
        logic               mem_we;
        logic [N_PORTS-1:0] port_sel;
        logic               dev_rd;
        logic               dev_wr;
        logic [DATA_W-1:0]  wdata;
        logic               ready;
        logic [DATA_W-1:0]  rdata;
        logic               err;
        logic [CNT_W-1:0]   cnt;
    } brc_regs_t;

    brc_regs_t r_d, r_q;

    logic               is_io;
    logic [N_PORTS-1:0] hit;
    logic               sel_ready;
    logic [DATA_W-1:0]  sel_rdata;

    brc_decode #(
        .ADDR_W(ADDR_W), .IO_AW(IO_AW), .N_PORTS(N_PORTS),
        .WIN_BASE(WIN_BASE), .PORT_NUMS(PORT_NUMS)
    ) u_decode (
        .mode_mmio(mode_mmio), .io_m(io_m), .addr(addr),
        .is_io(is_io), .hit(hit)
    );

    brc_port_mux #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_mux (
        .sel(r_q.port_sel), .port_ready(port_ready), .port_rdata(port_rdata),
        .any_ready(sel_ready), .rdata(sel_rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b0;
        r_d.err   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.rdata = '0;
                if (cyc_valid) begin
                    r_d.rd    = rd_wr;
                    r_d.wdata = wdata;
                    r_d.cnt   = '0;
                    if (is_io) begin
                        r_d.state    = ST_DEV;
                        r_d.port_sel = hit;
                        r_d.dev_rd   = rd_wr;
                        r_d.dev_wr   = !rd_wr;
                    end else begin
                        r_d.state   = ST_MEM;
                        r_d.mem_sel = 1'b1;
                        r_d.mem_we  = !rd_wr;
                    end
                end
            end
            ST_MEM: begin
                r_d.mem_sel = 1'b0;
                r_d.mem_we  = 1'b0;
                r_d.ready   = 1'b1;
                r_d.rdata   = r_q.rd ? mem_rdata : '0;
                r_d.state   = ST_DONE;
            end
            ST_DEV: begin
                if (|r_q.port_sel) begin
                    if (sel_ready) begin
                        r_d.ready    = 1'b1;
                        r_d.rdata    = r_q.rd ? sel_rdata : '0;
                        r_d.port_sel = '0;
                        r_d.dev_rd   = 1'b0;
                        r_d.dev_wr   = 1'b0;
                        r_d.state    = ST_DONE;
                    end
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.ready  = 1'b1;
                    r_d.err    = 1'b1;
                    r_d.rdata  = '1;
                    r_d.dev_rd = 1'b0;
                    r_d.dev_wr = 1'b0;
                    r_d.state  = ST_DONE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
                r_d.rdata = '0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_sel   = r_q.mem_sel;
    assign mem_we    = r_q.mem_we;
    assign port_sel  = r_q.port_sel;
    assign dev_rd    = r_q.dev_rd;
    assign dev_wr    = r_q.dev_wr;
    assign wr_data   = r_q.wdata;
    assign cpu_ready = r_q.ready;
    assign cpu_rdata = r_q.rdata;
    assign cpu_err   = r_q.err;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int N_PORTS = 4,
    parameter int TIMEOUT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_sel,
    input logic [N_PORTS-1:0] port_sel,
    input logic [N_PORTS-1:0] port_ready,
    input logic               dev_rd,
    input logic               dev_wr,
    input logic               cpu_ready,
    input logic               cpu_err
);
    localparam int WCNT_W = $clog2(TIMEOUT + 2) + 1;
    logic [WCNT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if ((dev_rd || dev_wr) && (port_sel == '0)) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));

    // R1
    mem_dev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (port_sel == '0) && !dev_rd && !dev_wr);

    // R1
    mem_ready_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |=> cpu_ready && !mem_sel);

    // R5
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));

    // R6
    dev_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_sel != '0) && ((port_sel & port_ready) == '0)) |=> $stable(port_sel) && !cpu_ready);

    // R7
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WCNT_W'(TIMEOUT));

    // R10
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_ready);
endmodule

bind bus_cycle_router brc_checker #(.N_PORTS(N_PORTS), .TIMEOUT(TIMEOUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .port_sel(port_sel),
    .port_ready(port_ready), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err)
);

// File: tb/bus_cycle_router_tb.sv
module bus_cycle_router_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_mmio = 1'b0;
    logic         cyc_valid = 1'b0;
    logic         io_m = 1'b0;
    logic         rd_wr = 1'b1;
    logic [31:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  mem_rdata;
    logic [3:0]   port_ready;
    logic [127:0] port_rdata;
    logic         mem_sel, mem_we, dev_rd, dev_wr, cpu_ready, cpu_err;
    logic [3:0]   port_sel;
    logic [31:0]  wr_data, cpu_rdata;
    logic [3:0]   stray = '0;
    logic [3:0]   age [4];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_cycle_router u_dut (
        .clk(clk), .rst_n(rst_n), .mode_mmio(mode_mmio), .cyc_valid(cyc_valid),
        .io_m(io_m), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
        .mem_rdata(mem_rdata), .port_ready(port_ready), .port_rdata(port_rdata),
        .mem_sel(mem_sel), .mem_we(mem_we), .port_sel(port_sel),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .wr_data(wr_data),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
    );

    // memory model: halves of the address swapped
    assign mem_rdata = {addr[15:0], addr[31:16]};

    // port model: port i acknowledges once selected for i+1 cycles
    for (genvar i = 0; i < 4; i++) begin : g_port
        always_ff @(posedge clk) age[i] <= port_sel[i] ? age[i] + 4'd1 : 4'd0;
        assign port_ready[i] = (port_sel[i] && (age[i] >= 4'(i + 1))) || stray[i];
        assign port_rdata[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // kind: 0 memory, 1 matched port, 2 unmatched port
    task automatic do_cycle(input bit md, input bit iom, input bit rd,
                            input logic [31:0] a, input logic [31:0] wd,
                            input int kind, input int idx,
                            input logic [3:0] strays, input bit hold);
        int lat;
        logic [3:0] exp_sel;
        logic [31:0] exp_rd;
        int exp_lat;
        string dreq;
        dreq = md ? "R3" : "R2";
        @(negedge clk);
        mode_mmio = md; io_m = iom; rd_wr = rd; addr = a; wdata = wd;
        cyc_valid = 1'b1; stray = strays;
        @(negedge clk);
        lat = 1;
        exp_sel = (kind == 1) ? 4'(1 << idx) : 4'h0;
        check(mem_sel == (kind == 0), dreq, "mem_sel", 32'(mem_sel), 32'(kind == 0));
        check(port_sel == exp_sel, "R4", "port_sel", 32'(port_sel), 32'(exp_sel));
        if (kind == 0) begin
            check(mem_we == !rd, "R1", "mem_we", 32'(mem_we), 32'(!rd));
        end else begin
            check(dev_rd == rd && dev_wr == !rd, "R5", "dev_rd/dev_wr",
                  {30'd0, dev_rd, dev_wr}, {30'd0, rd, !rd});
        end
        if (!rd) check(wr_data == wd, "R5", "wr_data", wr_data, wd);
        while (!cpu_ready && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (kind == 0) ? 2 : (kind == 1) ? 3 + idx : 17;
        if (kind == 0) exp_rd = rd ? {a[15:0], a[31:16]} : 32'h0;
        else if (kind == 1) exp_rd = rd ? 32'hC0DE_0000 + 32'(idx) : 32'h0;
        else exp_rd = 32'hFFFF_FFFF;
        check(lat == exp_lat, (kind == 0) ? "R1" : (kind == 1) ? "R6" : "R7",
              "ready latency", 32'(lat), 32'(exp_lat));
        check(cpu_rdata == exp_rd, (kind == 2) ? "R7" : "R6", "cpu_rdata", cpu_rdata, exp_rd);
        check(cpu_err == (kind == 2), "R10", "cpu_err", 32'(cpu_err), 32'(kind == 2));
        if (hold) begin
            @(negedge clk);
            check(!cpu_ready && !mem_sel && port_sel == 4'h0 && !dev_rd && !dev_wr,
                  "R8", "outputs after ready with valid held",
                  {27'd0, cpu_ready, mem_sel, |port_sel, dev_rd, dev_wr}, 32'h0);
        end
        cyc_valid = 1'b0;
        stray = '0;
        @(negedge clk);
        check(!cpu_ready, "R8", "ready pulse width", 32'(cpu_ready), 32'h0);
    endtask

    typedef struct packed {
        logic        md;
        logic        iom;
        logic        rd;
        logic [31:0] a;
        logic [31:0] wd;
        logic [1:0]  kind;
        logic [1:0]  idx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 32'h1234_5678, 32'h0,           2'd0, 2'd0}, // R1 read
        '{1'b0, 1'b0, 1'b0, 32'hB000_0060, 32'hDEAD_BEEF,   2'd0, 2'd0}, // R1 R2 write, window unused
        '{1'b0, 1'b1, 1'b1, 32'h0000_0060, 32'h0,           2'd1, 2'd0}, // R2 R4
        '{1'b0, 1'b1, 1'b0, 32'hABCD_0064, 32'h5555_AAAA,   2'd1, 2'd1}, // R2 upper bits ignored
        '{1'b0, 1'b1, 1'b1, 32'h0000_03F8, 32'h0,           2'd1, 2'd2}, // R4
        '{1'b0, 1'b1, 1'b0, 32'h0000_01F0, 32'h0BAD_F00D,   2'd1, 2'd3}, // R5 write
        '{1'b0, 1'b1, 1'b1, 32'h0000_0061, 32'h0,           2'd2, 2'd0}, // R7 near miss
        '{1'b1, 1'b0, 1'b1, 32'hB000_03F8, 32'h0,           2'd1, 2'd2}, // R3 io_m ignored
        '{1'b1, 1'b1, 1'b0, 32'hB000_01F0, 32'h1357_9BDF,   2'd1, 2'd3}, // R3
        '{1'b1, 1'b1, 1'b1, 32'h0000_0060, 32'h0,           2'd0, 2'd0}, // R3 outside window
        '{1'b1, 1'b0, 1'b0, 32'hB000_0010, 32'h2468_ACE0,   2'd2, 2'd0}, // R7 write in window
        '{1'b1, 1'b0, 1'b1, 32'hB001_0060, 32'h0,           2'd0, 2'd0}, // R3 just above
        '{1'b1, 1'b0, 1'b1, 32'hAFFF_FFFF, 32'h0,           2'd0, 2'd0}  // R3 just below
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 outputs during reset
        check({mem_sel, mem_we, port_sel, dev_rd, dev_wr, cpu_ready, cpu_err} == '0,
              "R9", "control outputs in reset",
              {22'd0, mem_sel, mem_we, port_sel, dev_rd, dev_wr, cpu_ready, cpu_err}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cpu_rdata == 0 && wr_data == 0 && !cpu_ready && port_sel == 0 && !mem_sel,
              "R9", "outputs after reset", cpu_rdata | wr_data, 32'h0);

        for (int v = 0; v < NV; v++) begin
            do_cycle(VECS[v].md, VECS[v].iom, VECS[v].rd, VECS[v].a, VECS[v].wd,
                     int'(VECS[v].kind), int'(VECS[v].idx), 4'h0, 1'b0);
        end

        // R6 unselected acknowledges during a matched access
        do_cycle(1'b0, 1'b1, 1'b1, 32'h0000_0064, 32'h0, 1, 1, 4'b1001, 1'b0);
        // R7 stray acknowledges during an unmatched access
        do_cycle(1'b0, 1'b1, 1'b1, 32'h0000_7777, 32'h0, 2, 0, 4'b1111, 1'b0);
        do_cycle(1'b1, 1'b0, 1'b0, 32'hB000_FFFF, 32'h1, 2, 0, 4'b0101, 1'b0);
        // R8 valid held through the ready cycle
        do_cycle(1'b0, 1'b0, 1'b1, 32'h0F0F_3C3C, 32'h0, 0, 0, 4'h0, 1'b1);
        do_cycle(1'b1, 1'b0, 1'b1, 32'hB000_0060, 32'h0, 1, 0, 4'h0, 1'b1);
        // R8 a new cycle right after a held one
        do_cycle(1'b0, 1'b1, 1'b0, 32'h0000_03F8, 32'hCAFE_0001, 1, 2, 4'h0, 1'b0);

        // R9 reset in the middle of a device cycle
        @(negedge clk);
        mode_mmio = 1'b0; io_m = 1'b1; rd_wr = 1'b1; addr = 32'h0000_0099; cyc_valid = 1'b1;
        repeat (4) @(negedge clk);
        cyc_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(!dev_rd && !dev_wr && !cpu_ready && !cpu_err, "R9", "outputs after mid-cycle reset",
              {28'd0, dev_rd, dev_wr, cpu_ready, cpu_err}, 32'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!cpu_ready && !cpu_err, "R10", "no late completion after reset",
              {30'd0, cpu_ready, cpu_err}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule